// File: doc/BRIEF.md
# Per-Core Interval Tick Timer

This block is one local tick timer of the kind a multi-core system places beside each processor core. A programmable prescaler divides the input clock into ticks, and a loadable down-counter counts those ticks and raises an interrupt each time it runs out. With auto-reload selected, the counter refills from its buffer and keeps firing at a fixed period. Without auto-reload, it fires once and then holds at zero until software starts it again.

Software reaches the block through a simple 32-bit register port with byte offsets local to this instance. There are six registers: a prescaler divide buffer, an interrupt count buffer, a control register, an interrupt status register, an interrupt enable register and a write-status register. A write to the count buffer only takes effect when the top bit of the written word is set. Every write to the divide buffer, count buffer or control register raises an acknowledge flag, and software clears that flag by writing one to it.

Top module: `core_tick_timer`

## Requirements
- R1: After reset every register reads zero, both counters are stopped and irq_o is low.
- R2: With divide buffer P at offset 0x00 and count buffer N > 0 at offset 0x08, a control write that sets bits 0 and 1 from zero makes interrupt status bit 0 set exactly N*(P+1) clock edges after the edge that accepts the write.
- R3: A write to offset 0x08 loads bits 30:0 into the count buffer only when bit 31 of the written word is 1. Otherwise the buffer keeps its value. The buffer reads back at 0x08 with bit 31 as 0.
- R4: With control bit 2 set (interval mode), the counter reloads from the buffer on expiry and sets the status again every N*(P+1) cycles.
- R5: With control bit 2 clear, the counter holds at zero after one expiry and sets no further status until it is restarted.
- R6: Interrupt status bit 0 (offset 0x30) is cleared by writing 1 to it. Writing 0 leaves it unchanged.
- R7: irq_o is high exactly when status bit 0 and interrupt enable bit 0 (offset 0x34) are both 1.
- R8: Write status at offset 0x40 sets bit 0 after any write to 0x00, bit 1 after any write to 0x08 (gated or not), and bit 3 after any write to 0x20, visible after the accepting edge. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: Clearing the start bits freezes both counters. Setting them again restarts counting from the buffered values, so a full N*(P+1) period follows.
- R10: A count buffer of zero never sets the status.
- R11: Control at offset 0x20 holds bits 2:0 only. The other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1 (with req_i) |
| addr_i | input | 8 | Byte offset within the instance |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The timing function is tried with several combinations of divide value and count: a minimal divide with count one, a divide of one with a short one-shot count, a divide of two in interval mode, and a long count paused partway through. Each measured latency separates the prescaler term (P+1) from the count term N. The interval run measures the period both across the first expiry and after a status clear, which shows whether the reload restores the full count or loses a tick. The paused run distinguishes a counter that freezes and restarts from its buffer from one that resumes or keeps running. The zero-count and ungated-write cases show that no expiry arises from an empty buffer and that a write without the load flag leaves the buffer untouched.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_DIV  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_EN   = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_WACK = 8'h40;

  // control bit positions
  localparam int CTL_TRUN = 0;
  localparam int CTL_IRUN = 1;
  localparam int CTL_AUTO = 2;

  // write-ack bit positions
  localparam int ACK_DIV  = 0;
  localparam int ACK_CNT  = 1;
  localparam int ACK_CTRL = 3;

  typedef struct packed {
    logic auto_rl;
    logic irun;
    logic trun;
  } ctl_t;
endpackage

// File: rtl/ctt_regs.sv
module ctt_regs
  import ctt_pkg::*;
#(
  parameter int DIV_W = 32,
  parameter int CNT_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              expire_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [CNT_W-1:0]  cnt_buf_o,
  output ctl_t              ctl_o,
  output logic              trestart_o,
  output logic              irestart_o,
  output logic              stat_o,
  output logic              en_o,
  output logic [3:0]        wack_o
);
  logic wr;
  logic wr_div, wr_cnt, wr_ctrl, wr_stat, wr_en, wr_wack;
  ctl_t ctl_new;

  assign wr      = req_i && we_i;
  assign wr_div  = wr && (addr_i == OFS_DIV);
  assign wr_cnt  = wr && (addr_i == OFS_CNT);
  assign wr_ctrl = wr && (addr_i == OFS_CTRL);
  assign wr_stat = wr && (addr_i == OFS_STAT);
  assign wr_en   = wr && (addr_i == OFS_EN);
  assign wr_wack = wr && (addr_i == OFS_WACK);

  assign ctl_new    = ctl_t'(wdata_i[2:0]);
  // restart on a 0->1 transition of a start bit
  assign trestart_o = wr_ctrl && ctl_new.trun && !ctl_o.trun;
  assign irestart_o = wr_ctrl && ctl_new.irun && !ctl_o.irun;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o     <= '0;
      cnt_buf_o <= '0;
      ctl_o     <= '0;
      stat_o    <= 1'b0;
      en_o      <= 1'b0;
      wack_o    <= '0;
    end else begin
      if (wr_div) div_o <= wdata_i[DIV_W-1:0];
      if (wr_cnt && wdata_i[DATA_W-1]) cnt_buf_o <= wdata_i[CNT_W-1:0];
      if (wr_ctrl) ctl_o <= ctl_new;
      if (wr_en) en_o <= wdata_i[0];
      // expiry wins over a simultaneous clear
      if (expire_i) stat_o <= 1'b1;
      else if (wr_stat && wdata_i[0]) stat_o <= 1'b0;
      for (int b = 0; b < 4; b++) begin
        if ((b == ACK_DIV && wr_div) || (b == ACK_CNT && wr_cnt) ||
            (b == ACK_CTRL && wr_ctrl))
          wack_o[b] <= 1'b1;
        else if (wr_wack && wdata_i[b])
          wack_o[b] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_DIV:  rdata_o[DIV_W-1:0] = div_o;
      OFS_CNT:  rdata_o[CNT_W-1:0] = cnt_buf_o;
      OFS_CTRL: rdata_o[2:0]       = ctl_o;
      OFS_STAT: rdata_o[0]         = stat_o;
      OFS_EN:   rdata_o[0]         = en_o;
      OFS_WACK: rdata_o[3:0]       = wack_o;
      default:  rdata_o            = '0;
    endcase
  end
endmodule

// File: rtl/ctt_prescale.sv
module ctt_prescale #(
  parameter int DIV_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] pcnt_o,
  output logic             tick_o
);
  assign tick_o = run_i && (pcnt_o == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pcnt_o <= '0;
    else if (restart_i) pcnt_o <= '0;
    else if (tick_o)   pcnt_o <= '0;
    else if (run_i)    pcnt_o <= pcnt_o + 1'b1;
  end
endmodule

// File: rtl/ctt_intcnt.sv
module ctt_intcnt #(
  parameter int CNT_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic             auto_i,
  input  logic [CNT_W-1:0] buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step     = run_i && tick_i && (cnt_o != '0);
  assign expire_o = step && (cnt_o == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '0;
    else if (restart_i) cnt_o <= buf_i;
    else if (expire_o)  cnt_o <= auto_i ? buf_i : '0;
    else if (step)      cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import ctt_pkg::*;
#(
  parameter int DIV_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = DATA_W - 1;

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] pcnt;
  logic [CNT_W-1:0] cnt_buf;
  logic [CNT_W-1:0] icnt;
  ctl_t             ctl;
  logic             trestart, irestart;
  logic             stat, en, tick, expire;
  logic [3:0]       wack;

  ctt_regs #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .expire_i(expire), .div_o(div), .cnt_buf_o(cnt_buf), .ctl_o(ctl),
    .trestart_o(trestart), .irestart_o(irestart), .stat_o(stat),
    .en_o(en), .wack_o(wack)
  );

  ctt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni, .run_i(ctl.trun), .restart_i(trestart),
    .div_i(div), .pcnt_o(pcnt), .tick_o(tick)
  );

  ctt_intcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(ctl.irun), .restart_i(irestart), .tick_i(tick),
    .auto_i(ctl.auto_rl), .buf_i(cnt_buf), .cnt_o(icnt), .expire_o(expire)
  );

  assign irq_o = stat && en;
endmodule

// File: rtl/ctt_chk.sv
module ctt_chk
  import ctt_pkg::*;
#(
  parameter int DIV_W = 32,
  parameter int CNT_W = 31
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [CNT_W-1:0]  cnt_buf,
  input logic [CNT_W-1:0]  icnt,
  input logic [DIV_W-1:0]  pcnt,
  input ctl_t              ctl,
  input logic              stat,
  input logic [3:0]        wack,
  input logic              irq_o
);
  logic wr_ctrl, wr_cnt, wr_stat1;
  assign wr_ctrl  = req_i && we_i && addr_i == OFS_CTRL;
  assign wr_cnt   = req_i && we_i && addr_i == OFS_CNT;
  assign wr_stat1 = req_i && we_i && addr_i == OFS_STAT && wdata_i[0];

  a_r3_gated_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cnt && !wdata_i[DATA_W-1]) |=> $stable(cnt_buf));

  a_r8_ctrl_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> wack[ACK_CTRL]);

  a_r6_stat_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat && !wr_stat1) |=> stat);

  a_r9_pre_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl.trun && !wr_ctrl) |=> $stable(pcnt));

  a_r5_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icnt == '0 && !ctl.auto_rl && !wr_ctrl) |=> icnt == '0);

  a_r10_no_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat && icnt == '0 && !wr_ctrl) |=> !stat);

  a_r7_irq_needs_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stat);
endmodule

bind core_tick_timer ctt_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .cnt_buf(cnt_buf), .icnt(icnt),
  .pcnt(pcnt), .ctl(ctl), .stat(stat), .wack(wack), .irq_o(irq_o)
);

// File: tb/core_tick_timer_tb.sv
module core_tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  int          cyc = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  core_tick_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  // edges from the last accepted write until irq is seen
  task automatic wait_irq(int lim, output int n);
    n = 0;
    while (!irq && n < lim) begin @(posedge clk); #1; n++; end
    if (!irq) n = -1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    logic [7:0] ofs [6] = '{8'h00, 8'h08, 8'h20, 8'h30, 8'h34, 8'h40};
    foreach (ofs[i]) begin rd(ofs[i], d); chk("R1 reg after reset", d, 0); end
    chk("R1 irq after reset", {31'b0, irq}, 0);
  endtask

  task automatic t_ctrl_bits;
    logic [31:0] d;
    wr(8'h20, 32'hFFFF_FFF8); rd(8'h20, d); chk("R11 upper ctrl bits", d, 0);
    wr(8'h20, 32'h0000_0004); rd(8'h20, d); chk("R11 ctrl readback", d, 4);
    wr(8'h20, 0);
    wr(8'h40, 32'hF);
  endtask

  task automatic t_cnt_gate;
    logic [31:0] d;
    wr(8'h08, 32'h0000_0123); rd(8'h08, d); chk("R3 ungated write ignored", d, 0);
    rd(8'h40, d); chk("R8 ack on ungated count write", d, 2);
    wr(8'h08, 32'h8000_0123); rd(8'h08, d); chk("R3 gated write loads", d, 32'h123);
    wr(8'h08, 32'h7FFF_0777); rd(8'h08, d); chk("R3 buffer kept", d, 32'h123);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R3 bit31 reads zero", d, 32'h7FFF_FFFF);
    wr(8'h40, 32'h2); rd(8'h40, d); chk("R8 count ack cleared", d, 0);
  endtask

  task automatic t_wack;
    logic [31:0] d;
    wr(8'h00, 5); rd(8'h40, d); chk("R8 divide ack", d, 1);
    wr(8'h20, 0); rd(8'h40, d); chk("R8 ctrl ack", d, 9);
    wr(8'h40, 0); rd(8'h40, d); chk("R8 write zero keeps", d, 9);
    wr(8'h40, 8); rd(8'h40, d); chk("R8 clear ctrl ack only", d, 1);
    wr(8'h40, 1); rd(8'h40, d); chk("R8 all clear", d, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] d; int n;
    wr(8'h00, 1); wr(8'h08, 32'h8000_0004); wr(8'h34, 1);
    wr(8'h20, 3); wait_irq(200, n); chk("R2 one-shot latency P=1 N=4", n, 8);
    rd(8'h30, d); chk("R2 status set", d, 1);
    wr(8'h34, 0); chk("R7 irq masked", {31'b0, irq}, 0);
    wr(8'h34, 1); chk("R7 irq unmasked", {31'b0, irq}, 1);
    wr(8'h30, 0); rd(8'h30, d); chk("R6 write zero keeps status", d, 1);
    wr(8'h30, 1); rd(8'h30, d); chk("R6 write one clears", d, 0);
    idle(60); rd(8'h30, d); chk("R5 no second expiry", d, 0);
    wr(8'h20, 0);
  endtask

  task automatic t_min;
    int n;
    wr(8'h00, 0); wr(8'h08, 32'h8000_0001);
    wr(8'h20, 3); wait_irq(50, n); chk("R2 latency P=0 N=1", n, 1);
    wr(8'h20, 0); wr(8'h30, 1);
  endtask

  task automatic t_interval;
    int n;
    wr(8'h00, 2); wr(8'h08, 32'h8000_0003);
    wr(8'h20, 7); wait_irq(200, n); chk("R4 first period P=2 N=3", n, 9);
    for (int k = 0; k < 2; k++) begin
      wr(8'h30, 1); wait_irq(200, n); chk("R4 reload period", n, 8);
    end
    wr(8'h20, 0); wr(8'h30, 1);
  endtask

  task automatic t_freeze;
    logic [31:0] d; int n;
    wr(8'h00, 0); wr(8'h08, 32'h8000_0014);
    wr(8'h20, 3); idle(10);
    wr(8'h20, 0); idle(40);
    rd(8'h30, d); chk("R9 frozen no expiry", d, 0);
    wr(8'h20, 3); wait_irq(200, n); chk("R9 restart full period", n, 20);
    wr(8'h20, 0); wr(8'h30, 1);
  endtask

  task automatic t_zero;
    logic [31:0] d;
    wr(8'h00, 0); wr(8'h08, 32'h8000_0000);
    wr(8'h20, 7); idle(100);
    rd(8'h30, d); chk("R10 zero count never fires", d, 0);
    wr(8'h20, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ctrl_bits();
    t_cnt_gate();
    t_wack();
    t_oneshot();
    t_min();
    t_interval();
    t_freeze();
    t_zero();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule